// File: doc/BRIEF.md
# Queued-Byte SPI Master Transmitter

This block is an SPI master that keeps a one-byte holding buffer in front of its shift register. Software writes a byte into the holding buffer while the transmit-empty flag is high. When the engine is idle, the byte moves into the shift register on the next clock and shifting starts. While a frame is shifting, software may queue the following byte. That byte enters the shift register on the same clock that ends the current frame, so consecutive frames leave the pins with no idle gap. The transmit-empty flag follows the holding buffer, not the shift register, so it rises again as soon as a queued byte has been taken.

Every frame is 8 bits, most significant bit first. Clock phase and polarity are selectable. The SCK period is 2, 8, 32 or 128 system clocks. A continuous mode keeps the engine running when nothing new is queued. In that mode the shift register, which rotates its own contents back into place during a frame, sends its last byte again. At the end of each frame the byte received on MISO is copied to the receive data register and the receive-full flag is set. That flag clears only through a status read made while it is set, followed by a data read.

Top module: `spi_qtx`

## Requirements
- R1: After reset, stat_tx_empty=1, stat_rx_full=0, busy=0, and sck equals cfg_cpol.
- R2: A write while stat_tx_empty=1 stores wr_data and drives stat_tx_empty low on the next cycle. If the engine is idle, one cycle later the byte moves into the shift register: stat_tx_empty returns to 1 and busy becomes 1.
- R3: A write while stat_tx_empty=0 is ignored. The queued byte is kept, and the frames sent contain only the bytes that were accepted.
- R4: Each frame sends 8 bits on mosi, most significant bit first. With cfg_cpha=0, the first bit is valid on mosi before the first SCK edge, and bits are sampled on leading edges. With cfg_cpha=1, mosi changes on leading edges and bits are sampled on trailing edges. A leading edge is one that moves sck away from cfg_cpol. sck rests at cfg_cpol whenever busy=0.
- R5: cfg_div values 0, 1, 2 and 3 give an SCK period of 2, 8, 32 and 128 clocks. busy stays high for exactly 8 SCK periods per frame.
- R6: A byte queued before the current frame ends starts on the clock that ends that frame. For N chained frames, busy stays high continuously for N×8 SCK periods.
- R7: When a frame ends, the 8 bits sampled from miso (first sample in bit 7) appear on rd_data, and stat_rx_full becomes 1.
- R8: stat_rx_full clears only when data_rd follows a stat_rd that was made while stat_rx_full=1. A data_rd without such a preceding status read leaves the flag set. Each clearing read uses up the arming.
- R9: If the clearing data_rd falls in the same cycle as a frame end, stat_rx_full stays 1, rd_data holds the new byte, and the arming is used up.
- R10: With cfg_loop=1 and no byte queued, the engine starts another frame with no gap, sending the same byte again, until cfg_loop is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_div | input | 2 | SCK rate select (period 2, 8, 32 or 128 clocks) |
| cfg_loop | input | 1 | Resend the last byte while nothing is queued |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to queue |
| stat_rd | input | 1 | Status register read strobe |
| stat_tx_empty | output | 1 | Holding buffer can take a byte |
| stat_rx_full | output | 1 | Received byte waiting |
| data_rd | input | 1 | Data register read strobe |
| rd_data | output | 8 | Receive data register |
| busy | output | 1 | A frame is shifting |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land in the same clock: a frame completing, which sets the receive-full flag, and the data read that would clear it. The bench arms the clear with a status read and starts a frame at a known cycle. It then counts clocks from the load, so that the data read arrives exactly on the clock that ends the frame. It expects the flag to stay set with the new byte on rd_data, and it expects a second data read, made without a new status read, to leave the flag set. A second collision, a write that arrives while a frame end is taking the queued byte, is covered by the back-to-back and ignored-write sequences. Those sequences compare the captured MOSI bytes and the busy time against values computed from the SCK period.

// File: rtl/spi_qtx_pkg.sv
package spi_qtx_pkg;

    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned DIV_SEL_W  = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic                 cpol;
        logic                 cpha;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 loop_en;
    } spi_cfg_t;

    typedef struct packed {
        logic stb;   // an SCK edge happens this cycle
        logic lead;  // that edge is the leading one of its bit
        logic last;  // that edge closes the frame
    } edge_ev_t;

    // Half SCK period in system clocks: 1, 4, 16, 64
    function automatic int unsigned half_period(input logic [DIV_SEL_W-1:0] sel);
        return 32'd1 << (32'(sel) * 2);
    endfunction

    function automatic logic is_sample_edge(input logic cpha, input logic lead);
        return cpha ? ~lead : lead;
    endfunction

endpackage

// File: rtl/spi_qtx_seq.sv
module spi_qtx_seq
    import spi_qtx_pkg::*;
#(
    parameter int unsigned DATA_W = FRAME_BITS,
    parameter int unsigned DIV_W  = DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             loop_en,
    input  logic             hold_full,
    output logic             busy,
    output logic             load,
    output logic             sck_phase,
    output edge_ev_t         ev
);
    localparam int unsigned EDGES  = 2 * DATA_W;
    localparam int unsigned EIDX_W = $clog2(EDGES);
    localparam int unsigned CNT_W  = 2 * ((1 << DIV_W) - 1) + 1;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [EIDX_W-1:0] eidx_q;
    logic              ph_q;
    logic [CNT_W-1:0]  half_m1;
    logic              tick;
    logic              last_edge;
    logic              keep_run;

    always_comb begin
        half_m1   = CNT_W'(half_period(div_sel) - 1);
        tick      = (state_q == SEQ_RUN) && (cnt_q == half_m1);
        last_edge = tick && (eidx_q == EIDX_W'(EDGES - 1));
        load      = hold_full && ((state_q == SEQ_IDLE) || last_edge);
        keep_run  = last_edge && (hold_full || loop_en);
        ev.stb    = tick;
        ev.lead   = ~eidx_q[0];
        ev.last   = last_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            eidx_q  <= '0;
            ph_q    <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (load) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                        eidx_q  <= '0;
                        ph_q    <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        cnt_q <= '0;
                        ph_q  <= ~ph_q;
                        if (last_edge) begin
                            eidx_q <= '0;
                            if (!keep_run) state_q <= SEQ_IDLE;
                        end else begin
                            eidx_q <= eidx_q + EIDX_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign busy      = (state_q == SEQ_RUN);
    assign sck_phase = ph_q;

endmodule

// File: rtl/spi_qtx_tx.sv
module spi_qtx_tx
    import spi_qtx_pkg::*;
#(
    parameter int unsigned DATA_W = FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              edge_stb,
    input  logic              edge_lead,
    output logic              tx_empty,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_view,
    output logic              mosi
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] sh_q;
    logic              empty_q;
    logic              mosi_q;
    logic              accept;
    logic              shift_now;

    always_comb begin
        accept    = wr_en && empty_q;
        shift_now = edge_stb && !is_sample_edge(cpha, edge_lead);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            sh_q    <= '0;
            empty_q <= 1'b1;
            mosi_q  <= 1'b0;
        end else begin
            if (accept) begin
                hold_q  <= wr_data;
                empty_q <= 1'b0;
            end
            if (shift_now) begin
                // rotate so a full frame restores the byte for a repeat
                sh_q <= {sh_q[DATA_W-2:0], sh_q[DATA_W-1]};
                if (cpha) mosi_q <= sh_q[DATA_W-1];
            end
            if (load) begin
                sh_q    <= hold_q;
                empty_q <= 1'b1;
            end
        end
    end

    assign tx_empty  = empty_q;
    assign hold_full = ~empty_q;
    assign hold_view = hold_q;
    assign mosi      = cpha ? mosi_q : sh_q[DATA_W-1];

endmodule

// File: rtl/spi_qtx_rx.sv
module spi_qtx_rx
    import spi_qtx_pkg::*;
#(
    parameter int unsigned DATA_W = FRAME_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  logic              miso,
    input  edge_ev_t          ev,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_next;
    logic              full_q;
    logic              armed_q;
    logic              sample;
    logic              clear_req;

    always_comb begin
        sample    = ev.stb && is_sample_edge(cpha, ev.lead);
        rx_next   = sample ? {sh_q[DATA_W-2:0], miso} : sh_q;
        clear_req = data_rd && armed_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            rx_q    <= '0;
            full_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (sample) sh_q <= rx_next;
            if (stat_rd && full_q) armed_q <= 1'b1;
            if (clear_req) armed_q <= 1'b0;
            if (ev.last) begin
                rx_q   <= rx_next;
                full_q <= 1'b1;
            end else if (clear_req) begin
                full_q <= 1'b0;
            end
        end
    end

    assign rx_data = rx_q;
    assign rx_full = full_q;

endmodule

// File: rtl/spi_qtx.sv
module spi_qtx
    import spi_qtx_pkg::*;
#(
    parameter int unsigned DATA_W = FRAME_BITS,
    parameter int unsigned DIV_W  = DIV_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_loop,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic              stat_tx_empty,
    output logic              stat_rx_full,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    spi_cfg_t          cfg;
    edge_ev_t          ev;
    logic              load;
    logic              hold_full;
    logic              sck_phase;
    logic [DATA_W-1:0] hold_q_w;
    logic              frame_last_w;

    always_comb begin
        cfg.cpol    = cfg_cpol;
        cfg.cpha    = cfg_cpha;
        cfg.div_sel = cfg_div;
        cfg.loop_en = cfg_loop;
    end

    spi_qtx_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (cfg.div_sel),
        .loop_en   (cfg.loop_en),
        .hold_full (hold_full),
        .busy      (busy),
        .load      (load),
        .sck_phase (sck_phase),
        .ev        (ev)
    );

    spi_qtx_tx #(.DATA_W(DATA_W)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .cpha      (cfg.cpha),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .edge_stb  (ev.stb),
        .edge_lead (ev.lead),
        .tx_empty  (stat_tx_empty),
        .hold_full (hold_full),
        .hold_view (hold_q_w),
        .mosi      (mosi)
    );

    spi_qtx_rx #(.DATA_W(DATA_W)) rx_i (
        .clk     (clk),
        .rst     (rst),
        .cpha    (cfg.cpha),
        .miso    (miso),
        .ev      (ev),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .rx_data (rd_data),
        .rx_full (stat_rx_full)
    );

    assign sck          = sck_phase ^ cfg.cpol;
    assign frame_last_w = ev.last;

endmodule

// File: rtl/spi_qtx_chk.sv
module spi_qtx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_cpol,
    input logic              wr_en,
    input logic              stat_tx_empty,
    input logic              stat_rx_full,
    input logic              data_rd,
    input logic              busy,
    input logic              sck,
    input logic              frame_last,
    input logic [DATA_W-1:0] hold_q
);
    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        wr_en && stat_tx_empty |=> !stat_tx_empty); // R2
    AST_IDLE_TAKES_BYTE: assert property (@(posedge clk) disable iff (rst)
        !busy && !stat_tx_empty |=> busy && stat_tx_empty); // R2
    AST_QUEUED_BYTE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !stat_tx_empty |=> $stable(hold_q)); // R3
    AST_SCK_RESTS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck == cfg_cpol); // R4
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        busy && !frame_last |=> busy); // R6
    AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        frame_last |=> stat_rx_full); // R7
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
        stat_rx_full && !data_rd |=> stat_rx_full); // R8
endmodule

bind spi_qtx spi_qtx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_cpol      (cfg_cpol),
    .wr_en         (wr_en),
    .stat_tx_empty (stat_tx_empty),
    .stat_rx_full  (stat_rx_full),
    .data_rd       (data_rd),
    .busy          (busy),
    .sck           (sck),
    .frame_last    (frame_last_w),
    .hold_q        (hold_q_w)
);

// File: tb/spi_qtx_tb_top.sv
`timescale 1ns/1ps
module spi_qtx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_loop = 1'b0;
    logic [1:0] cfg_div = 2'd0;
    logic       wr_en = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_tx_empty, stat_rx_full, busy, sck, mosi, miso;
    logic [7:0] rd_data;
    logic       inv = 1'b0;

    always #2 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_qtx dut_i (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_div(cfg_div), .cfg_loop(cfg_loop), .wr_en(wr_en), .wr_data(wr_data),
        .stat_rd(stat_rd), .stat_tx_empty(stat_tx_empty), .stat_rx_full(stat_rx_full),
        .data_rd(data_rd), .rd_data(rd_data), .busy(busy), .sck(sck),
        .mosi(mosi), .miso(miso)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // MOSI capture on sample edges
    logic [7:0] cap [0:31];
    int   cap_n = 0;
    int   mon_bits = 0;
    logic [7:0] mon_sh = 8'h00;
    bit   mon_en = 0;

    always @(sck) begin
        #1;
        if (mon_en) begin
            if (cfg_cpha ? (sck == cfg_cpol) : (sck != cfg_cpol)) begin
                mon_sh = {mon_sh[6:0], mosi};
                mon_bits++;
                if (mon_bits == 8) begin
                    if (cap_n < 32) cap[cap_n] = mon_sh;
                    cap_n++;
                    mon_bits = 0;
                end
            end
        end
    end

    int  busy_cyc = 0;
    int  falls = 0;
    logic prev_busy = 1'b0;
    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (prev_busy && !busy) falls++;
        prev_busy = busy;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic stat_read();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic data_read();
        data_rd = 1'b1; step(); data_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((busy || !stat_tx_empty) && n < 20000) begin
            step();
            n++;
        end
        step();
    endtask

    task automatic setup(input logic p, input logic h, input logic [1:0] d,
                         input logic lp, input logic iv);
        mon_en = 0;
        cfg_cpol = p; cfg_cpha = h; cfg_div = d; cfg_loop = lp; inv = iv;
        step(); step();
        cap_n = 0; mon_bits = 0; busy_cyc = 0; falls = 0;
        mon_en = 1;
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0] b, x, y, z;
        int half;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk(stat_tx_empty == 1'b1, "R1 tx_empty", stat_tx_empty, 1);
        chk(stat_rx_full == 1'b0, "R1 rx_full", stat_rx_full, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sck == 1'b0, "R1 sck", sck, 0);

        // Sweep every mode and rate with a single frame
        for (int idx = 0; idx < 16; idx++) begin
            logic p, h;
            logic [1:0] d;
            p = idx[3]; h = idx[2]; d = idx[1:0];
            half = 1 << (2 * d);
            b = 8'hA5 ^ 8'(idx * 37);
            setup(p, h, d, 1'b0, idx[0]);
            do_write(b);
            chk(stat_tx_empty == 1'b0, "R2 empty low after write", stat_tx_empty, 0);
            chk(busy == 1'b0, "R2 not yet busy", busy, 0);
            step();
            chk(stat_tx_empty == 1'b1 && busy == 1'b1, "R2 moved to shifter",
                {stat_tx_empty, busy}, 3);
            if (!h) chk(mosi == b[7], "R4 first bit before first edge", mosi, b[7]);
            chk(sck == p, "R4 sck before first edge", sck, p);
            wait_idle();
            chk(cap_n == 1 && cap[0] == b, "R4 mosi byte", cap[0], b);
            chk(busy_cyc == 16 * half, "R5 frame length", busy_cyc, 16 * half);
            chk(sck == p, "R4 sck rests", sck, p);
            chk(stat_rx_full == 1'b1, "R7 rx_full set", stat_rx_full, 1);
            chk(rd_data == (b ^ {8{idx[0]}}), "R7 rx byte", rd_data, b ^ {8{idx[0]}});
            stat_read();
            data_read();
            chk(stat_rx_full == 1'b0, "R8 cleared by status then data", stat_rx_full, 0);
        end

        // R6 three chained frames, CPHA=1 CPOL=0
        setup(1'b0, 1'b1, 2'd1, 1'b0, 1'b0);
        do_write(8'h3C);
        step();
        do_write(8'hC1);
        while (!stat_tx_empty) step();
        do_write(8'h5E);
        wait_idle();
        chk(cap_n == 3, "R6 frame count", cap_n, 3);
        chk(cap[0] == 8'h3C && cap[1] == 8'hC1 && cap[2] == 8'h5E, "R6 order",
            {cap[0], cap[1], cap[2]}, 24'h3CC15E);
        chk(busy_cyc == 3 * 16 * 4, "R6 no gap length", busy_cyc, 192);
        chk(falls == 1, "R6 single busy span", falls, 1);
        chk(rd_data == 8'h5E, "R7 last rx byte", rd_data, 8'h5E);

        // R3 write while buffer full is ignored
        setup(1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        do_write(8'h81);
        step();
        do_write(8'h42);
        chk(stat_tx_empty == 1'b0, "R3 queued", stat_tx_empty, 0);
        do_write(8'hFF);
        chk(stat_tx_empty == 1'b0, "R3 still full", stat_tx_empty, 0);
        wait_idle();
        chk(cap_n == 2, "R3 frame count", cap_n, 2);
        chk(cap[0] == 8'h81 && cap[1] == 8'h42, "R3 queued byte kept",
            {cap[0], cap[1]}, 16'h8142);

        // R8 clearing rules
        chk(stat_rx_full == 1'b1, "R8 full before", stat_rx_full, 1);
        data_read();
        chk(stat_rx_full == 1'b1, "R8 data read alone", stat_rx_full, 1);
        stat_read();
        data_read();
        chk(stat_rx_full == 1'b0, "R8 status then data", stat_rx_full, 0);
        stat_read();                  // flag clear: must not arm
        do_write(8'h19);
        wait_idle();
        data_read();
        chk(stat_rx_full == 1'b1, "R8 status read while clear does not arm", stat_rx_full, 1);

        // R9 clearing read in the frame-end cycle
        setup(1'b0, 1'b1, 2'd1, 1'b0, 1'b1);
        x = 8'h6B; y = 8'hD2;
        do_write(x);
        wait_idle();
        stat_read();
        do_write(y);
        step();
        chk(busy == 1'b1, "R9 frame started", busy, 1);
        repeat (63) step();
        data_rd = 1'b1;
        step();
        data_rd = 1'b0;
        chk(busy == 1'b0, "R9 frame end aligned", busy, 0);
        chk(stat_rx_full == 1'b1, "R9 set wins", stat_rx_full, 1);
        chk(rd_data == (y ^ 8'hFF), "R9 new byte", rd_data, y ^ 8'hFF);
        data_read();
        chk(stat_rx_full == 1'b1, "R9 arming used up", stat_rx_full, 1);
        stat_read();
        data_read();
        chk(stat_rx_full == 1'b0, "R8 clear after collision", stat_rx_full, 0);

        // R10 continuous mode repeats the last byte
        setup(1'b1, 1'b0, 2'd0, 1'b1, 1'b0);
        z = 8'h9A;
        do_write(z);
        begin
            int n = 0;
            while (cap_n < 3 && n < 2000) begin step(); n++; end
        end
        cfg_loop = 1'b0;
        wait_idle();
        chk(cap_n >= 3, "R10 repeated frames", cap_n, 3);
        for (int i = 0; i < 3; i++)
            chk(cap[i] == z, "R10 same byte", cap[i], z);
        chk(falls == 1, "R10 no gap", falls, 1);
        chk(busy_cyc == cap_n * 16, "R10 length", busy_cyc, cap_n * 16);

        finish_up();
    end
endmodule